// File: doc/BRIEF.md
# NAND Bus Cycle Timing Sequencer

This block turns one host request at a time into a single NAND flash bus cycle. A request is either a command cycle, an address cycle or a data cycle, and data cycles can be reads or writes. The sequencer selects one of four chip-enable lines and drives the command-latch and address-latch lines, the write and read strobes, and a one-byte data bus with an output enable. Every phase length is counted in host-clock cycles and comes from a timing field supplied with the request.

The sequence runs through an optional read turnaround, a setup phase, a strobe phase and a hold phase, and ends with a single done cycle. A read data cycle that directly follows a command cycle waits for the command-latch-to-read delay before it starts. A read that directly follows an address cycle waits for the address-latch-to-read delay instead. On write cycles the data bus stays released for a programmable number of cycles from the start of the access. The byte captured on a read is returned on a holding register, and a one-cycle done pulse tells the requester that the cycle has finished.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset, all chip enables are high (`nce` = 4'hF). `cle`, `ale`, `dq_oe` and `done` are low, `nwe` and `nre` are high, `rd_data` is 0 and `req_ready` is 1.
- R2: `req_kind` 2'b00 is a command cycle, with `cle` high. 2'b01 is an address cycle, with `ale` high. 2'b10 and 2'b11 are data cycles, with both lines low. The latch lines hold these levels through setup, strobe and hold, and are low at every other time.
- R3: The setup phase lasts `cfg_setup`+1 cycles, starting in the cycle after acceptance (or after the turnaround). During setup both strobes are high.
- R4: The strobe phase follows setup and lasts `cfg_strobe`+1 cycles. Command and address cycles are always writes and pull `nwe` low. Data cycles pull `nwe` low when `req_write`=1 and pull `nre` low when `req_write`=0. The two strobes are never low together.
- R5: The hold phase lasts `cfg_hold`+1 cycles. Strobes are high, while the latch lines and the write byte on `dq_out` are kept. Then comes one cycle with `done`=1 and all chip enables high, followed by idle. `req_ready` is 1 only in idle, and a `req_valid` seen outside idle is ignored.
- R6: On write cycles, `dq_oe` is low for the first `cfg_hiz` cycles of the access, counted from the first setup cycle. It is then high until the end of hold, with `dq_out` equal to the latched byte. `cfg_hiz`=0 means no released time. On reads, `dq_oe` is never high.
- R7: On a read, `rd_data` takes `dq_in` at the clock edge that ends the last strobe cycle. It is visible from the first hold cycle and is kept until the next read capture.
- R8: A read data cycle whose previous completed cycle was a command is preceded by a turnaround of `cfg_cle_re`+1 cycles. If the previous cycle was an address, the turnaround is `cfg_ale_re`+1 cycles. In every other case there is no turnaround. During the turnaround the bank's chip enable is low, the latch lines are low and both strobes are high.
- R9: From turnaround to end of hold, exactly the chip enable `nce[req_bank]` is low. All chip enables are high in idle and in the done cycle.
- R10: The kind, direction, write byte, bank and all timing fields are taken at acceptance. Changing them during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 command, 01 address, 1x data |
| req_write | input | 1 | Data cycle direction, 1 = write |
| req_wdata | input | 8 | Byte to drive on writes |
| req_bank | input | 2 | Bank to select |
| cfg_setup | input | 8 | Setup length minus one |
| cfg_strobe | input | 8 | Strobe length minus one |
| cfg_hold | input | 8 | Hold length minus one |
| cfg_hiz | input | 8 | Write bus-release cycles |
| cfg_cle_re | input | 4 | Command-to-read delay minus one |
| cfg_ale_re | input | 4 | Address-to-read delay minus one |
| dq_in | input | 8 | Flash data bus input |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last captured read byte |
| nce | output | 4 | Active-low chip enables |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| nwe | output | 1 | Active-low write strobe |
| nre | output | 1 | Active-low read strobe |
| dq_out | output | 8 | Flash data bus output |
| dq_oe | output | 1 | Data bus output enable |

## Verification
All pin outputs are decoded from registered state, so a request accepted at one edge shows its first turnaround or setup cycle right after that edge. Each later phase boundary falls at an exact cycle count from acceptance: turnaround length, then `cfg_setup`+1, `cfg_strobe`+1 and `cfg_hold`+1 cycles, then the done cycle. The bench numbers the cycles after the accepting edge. It samples every pin at the falling edge of each numbered cycle against the phase that count predicts. It drives the real read byte on `dq_in` only during the last strobe cycle, so a capture one cycle early or late is caught. It reads `rd_data` in the first hold cycle and again in idle.

// File: rtl/nand_seq_pkg.sv
// Shared types for the NAND bus cycle sequencer.
// Assumes: request kind 2'b00 command, 2'b01 address, 2'b1x data.
package nand_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_TURN   = 3'd1,
        PH_SETUP  = 3'd2,
        PH_ASSERT = 3'd3,
        PH_HOLD   = 3'd4,
        PH_DONE   = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        PREV_NONE = 2'd0,
        PREV_CMD  = 2'd1,
        PREV_ADDR = 2'd2
    } prev_e;

    typedef struct packed {
        logic is_cmd;
        logic is_addr;
        logic is_write;
    } cyc_flags_t;

    localparam logic [1:0] KIND_CMD  = 2'b00;
    localparam logic [1:0] KIND_ADDR = 2'b01;

    // Turn a request kind and direction into cycle flags.
    function automatic cyc_flags_t decode_kind(input logic [1:0] kind, input logic wr);
        cyc_flags_t f;
        f.is_cmd   = (kind == KIND_CMD);
        f.is_addr  = (kind == KIND_ADDR);
        f.is_write = f.is_cmd || f.is_addr || wr;
        return f;
    endfunction

endpackage

// File: rtl/nand_seq_req_latch.sv
// Request capture for the NAND sequencer.
// Latches the request fields and timing at acceptance, and remembers the
// kind of the last completed cycle. From that it decides whether an incoming
// read needs a turnaround, and how long it is.
// Assumes: PHASE_W > DELAY_W; accept is only raised in idle.
module nand_seq_req_latch
    import nand_seq_pkg::*;
#(
    parameter int BANK_W  = 2,
    parameter int DATA_W  = 8,
    parameter int PHASE_W = 8,
    parameter int DELAY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic               done_tick,
    input  logic [1:0]         req_kind,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [BANK_W-1:0]  req_bank,
    input  logic [PHASE_W-1:0] cfg_setup,
    input  logic [PHASE_W-1:0] cfg_strobe,
    input  logic [PHASE_W-1:0] cfg_hold,
    input  logic [DELAY_W-1:0] cfg_cle_re,
    input  logic [DELAY_W-1:0] cfg_ale_re,
    output cyc_flags_t         lat_flags,
    output logic [DATA_W-1:0]  lat_wdata,
    output logic [BANK_W-1:0]  lat_bank,
    output logic [PHASE_W-1:0] lat_setup,
    output logic [PHASE_W-1:0] lat_strobe,
    output logic [PHASE_W-1:0] lat_hold,
    output logic               acc_turn,
    output logic [PHASE_W-1:0] acc_turn_len
);

    localparam int PAD_W = PHASE_W - DELAY_W;

    cyc_flags_t in_flags;
    prev_e      prev_q;

    // Decode the incoming request and pick the turnaround it needs.
    always_comb begin
        in_flags = decode_kind(req_kind, req_write);
        acc_turn = !in_flags.is_write && (prev_q != PREV_NONE);
        if (prev_q == PREV_CMD) begin
            acc_turn_len = {{PAD_W{1'b0}}, cfg_cle_re};
        end else begin
            acc_turn_len = {{PAD_W{1'b0}}, cfg_ale_re};
        end
    end

    // Capture request fields and timing when the request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_flags  <= '0;
            lat_wdata  <= '0;
            lat_bank   <= '0;
            lat_setup  <= '0;
            lat_strobe <= '0;
            lat_hold   <= '0;
        end else if (accept) begin
            lat_flags  <= in_flags;
            lat_wdata  <= req_wdata;
            lat_bank   <= req_bank;
            lat_setup  <= cfg_setup;
            lat_strobe <= cfg_strobe;
            lat_hold   <= cfg_hold;
        end
    end

    // Record the kind of each cycle as it completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= PREV_NONE;
        end else if (done_tick) begin
            if (lat_flags.is_cmd) begin
                prev_q <= PREV_CMD;
            end else if (lat_flags.is_addr) begin
                prev_q <= PREV_ADDR;
            end else begin
                prev_q <= PREV_NONE;
            end
        end
    end

endmodule

// File: rtl/nand_seq_phase_fsm.sv
// Phase sequencer: IDLE, optional TURN, SETUP, ASSERT, HOLD, DONE.
// Each timed phase is loaded with its field value N and lasts N+1 cycles.
// Assumes: the first phase length comes from the raw inputs at acceptance;
// later phases use the latched copies.
module nand_seq_phase_fsm
    import nand_seq_pkg::*;
#(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic               acc_turn,
    input  logic [PHASE_W-1:0] acc_turn_len,
    input  logic [PHASE_W-1:0] cfg_setup,
    input  logic [PHASE_W-1:0] lat_setup,
    input  logic [PHASE_W-1:0] lat_strobe,
    input  logic [PHASE_W-1:0] lat_hold,
    output phase_e             phase,
    output logic               capture,
    output logic               done_tick
);

    logic [PHASE_W-1:0] cnt_q;
    logic               last;

    // Flag the final cycle of the current timed phase.
    always_comb begin
        last      = (cnt_q == '0);
        capture   = (phase == PH_ASSERT) && last;
        done_tick = (phase == PH_DONE);
    end

    // Advance through the phases and reload the counter at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (accept && acc_turn) begin
                        phase <= PH_TURN;
                        cnt_q <= acc_turn_len;
                    end else if (accept) begin
                        phase <= PH_SETUP;
                        cnt_q <= cfg_setup;
                    end
                end
                PH_TURN: begin
                    if (last) begin
                        phase <= PH_SETUP;
                        cnt_q <= lat_setup;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        phase <= PH_ASSERT;
                        cnt_q <= lat_strobe;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_ASSERT: begin
                    if (last) begin
                        phase <= PH_HOLD;
                        cnt_q <= lat_hold;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last) begin
                        phase <= PH_DONE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/nand_seq_hiz_gate.sv
// Write bus-release counter.
// Loaded with the release count at acceptance and counted down once per
// cycle of setup, strobe and hold. drive_ok rises once it reaches zero.
// Assumes: writes never use the turnaround phase.
module nand_seq_hiz_gate
    import nand_seq_pkg::*;
#(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic [PHASE_W-1:0] cfg_hiz,
    input  phase_e             phase,
    output logic               drive_ok
);

    logic [PHASE_W-1:0] hiz_q;
    logic               in_access;

    // Recognise the phases that count toward the release window.
    always_comb begin
        in_access = (phase == PH_SETUP) || (phase == PH_ASSERT) || (phase == PH_HOLD);
        drive_ok  = (hiz_q == '0);
    end

    // Load at acceptance, then count down to zero during the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hiz_q <= '0;
        end else if (accept) begin
            hiz_q <= cfg_hiz;
        end else if (in_access && !drive_ok) begin
            hiz_q <= hiz_q - 1'b1;
        end
    end

endmodule

// File: rtl/nand_seq_pin_drive.sv
// Pin decode for the NAND sequencer.
// Drives the chip enables, latch lines, strobes and data bus from the phase
// and the latched request, and holds the captured read byte.
// Assumes: BANKS fits in BANK_W bits.
module nand_seq_pin_drive
    import nand_seq_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int BANK_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  cyc_flags_t        lat_flags,
    input  logic [BANK_W-1:0] lat_bank,
    input  logic [DATA_W-1:0] lat_wdata,
    input  logic              drive_ok,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [BANKS-1:0]  nce,
    output logic              cle,
    output logic              ale,
    output logic              nwe,
    output logic              nre,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    logic active;
    logic latch_ph;
    logic strobe_ph;

    // Classify the current phase for the pin decode.
    always_comb begin
        latch_ph  = (phase == PH_SETUP) || (phase == PH_ASSERT) || (phase == PH_HOLD);
        active    = latch_ph || (phase == PH_TURN);
        strobe_ph = (phase == PH_ASSERT);
    end

    // One active-low enable per bank.
    for (genvar b = 0; b < BANKS; b++) begin : g_ce
        localparam logic [BANK_W-1:0] BANK_ID = BANK_W'(b);
        assign nce[b] = !(active && (lat_bank == BANK_ID));
    end

    // Latch lines, strobes and the write data bus.
    always_comb begin
        cle    = latch_ph && lat_flags.is_cmd;
        ale    = latch_ph && lat_flags.is_addr;
        nwe    = !(strobe_ph && lat_flags.is_write);
        nre    = !(strobe_ph && !lat_flags.is_write);
        dq_oe  = latch_ph && lat_flags.is_write && drive_ok;
        dq_out = (latch_ph && lat_flags.is_write) ? lat_wdata : '0;
        done   = (phase == PH_DONE);
    end

    // Take the read byte at the end of the last strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (capture && !lat_flags.is_write) begin
            rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/nand_cycle_seq.sv
// NAND bus cycle timing sequencer, top level.
// Accepts one command, address or data request at a time while idle and runs
// it as a single timed flash bus cycle, ending with a one-cycle done pulse.
// Assumes: requests are held by the requester until req_ready is seen.
module nand_cycle_seq
    import nand_seq_pkg::*;
#(
    parameter int BANKS    = 4,
    parameter int DATA_W   = 8,
    parameter int PHASE_W  = 8,
    parameter int DELAY_W  = 4,
    localparam int BANK_W  = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [BANK_W-1:0]  req_bank,
    input  logic [PHASE_W-1:0] cfg_setup,
    input  logic [PHASE_W-1:0] cfg_strobe,
    input  logic [PHASE_W-1:0] cfg_hold,
    input  logic [PHASE_W-1:0] cfg_hiz,
    input  logic [DELAY_W-1:0] cfg_cle_re,
    input  logic [DELAY_W-1:0] cfg_ale_re,
    input  logic [DATA_W-1:0]  dq_in,
    output logic               req_ready,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data,
    output logic [BANKS-1:0]   nce,
    output logic               cle,
    output logic               ale,
    output logic               nwe,
    output logic               nre,
    output logic [DATA_W-1:0]  dq_out,
    output logic               dq_oe
);

    phase_e             phase;
    cyc_flags_t         lat_flags;
    logic [DATA_W-1:0]  lat_wdata;
    logic [BANK_W-1:0]  lat_bank;
    logic [PHASE_W-1:0] lat_setup;
    logic [PHASE_W-1:0] lat_strobe;
    logic [PHASE_W-1:0] lat_hold;
    logic               acc_turn;
    logic [PHASE_W-1:0] acc_turn_len;
    logic               accept;
    logic               capture;
    logic               done_tick;
    logic               drive_ok;

    // Accept only while idle.
    always_comb begin
        req_ready = (phase == PH_IDLE);
        accept    = req_valid && req_ready;
    end

    nand_seq_req_latch #(
        .BANK_W  (BANK_W),
        .DATA_W  (DATA_W),
        .PHASE_W (PHASE_W),
        .DELAY_W (DELAY_W)
    ) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .done_tick    (done_tick),
        .req_kind     (req_kind),
        .req_write    (req_write),
        .req_wdata    (req_wdata),
        .req_bank     (req_bank),
        .cfg_setup    (cfg_setup),
        .cfg_strobe   (cfg_strobe),
        .cfg_hold     (cfg_hold),
        .cfg_cle_re   (cfg_cle_re),
        .cfg_ale_re   (cfg_ale_re),
        .lat_flags    (lat_flags),
        .lat_wdata    (lat_wdata),
        .lat_bank     (lat_bank),
        .lat_setup    (lat_setup),
        .lat_strobe   (lat_strobe),
        .lat_hold     (lat_hold),
        .acc_turn     (acc_turn),
        .acc_turn_len (acc_turn_len)
    );

    nand_seq_phase_fsm #(
        .PHASE_W (PHASE_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .acc_turn     (acc_turn),
        .acc_turn_len (acc_turn_len),
        .cfg_setup    (cfg_setup),
        .lat_setup    (lat_setup),
        .lat_strobe   (lat_strobe),
        .lat_hold     (lat_hold),
        .phase        (phase),
        .capture      (capture),
        .done_tick    (done_tick)
    );

    nand_seq_hiz_gate #(
        .PHASE_W (PHASE_W)
    ) u_hiz (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .cfg_hiz  (cfg_hiz),
        .phase    (phase),
        .drive_ok (drive_ok)
    );

    nand_seq_pin_drive #(
        .BANKS  (BANKS),
        .BANK_W (BANK_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .lat_flags (lat_flags),
        .lat_bank  (lat_bank),
        .lat_wdata (lat_wdata),
        .drive_ok  (drive_ok),
        .capture   (capture),
        .dq_in     (dq_in),
        .nce       (nce),
        .cle       (cle),
        .ale       (ale),
        .nwe       (nwe),
        .nre       (nre),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .rd_data   (rd_data),
        .done      (done)
    );

endmodule

// File: rtl/nand_cycle_seq_chk.sv
// Protocol checker for the NAND sequencer, bound to every instance.
// Assumes: synchronous active-low reset.
module nand_cycle_seq_chk #(
    parameter int BANKS  = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic [BANKS-1:0]  nce,
    input logic              cle,
    input logic              ale,
    input logic              nwe,
    input logic              nre,
    input logic              dq_oe,
    input logic [DATA_W-1:0] rd_data
);

    // At most one chip enable is active.
    assert_ce_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~nce) <= 1);

    // The two strobes are never active together.
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nwe && !nre));

    // Command and address latch lines are never raised together.
    assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    // Done lasts one cycle and is followed by idle.
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // No chip enable during the done cycle.
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (nce == {BANKS{1'b1}}));

    // While idle, the bus is quiet.
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ((nce == {BANKS{1'b1}}) && nwe && nre && !dq_oe && !cle && !ale));

    // The bus is never driven while reading.
    assert_no_drive_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !nre |-> !dq_oe);

    // Read data changes only just after a read strobe.
    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (nre && $past(nre)) |-> $stable(rd_data));

endmodule

bind nand_cycle_seq nand_cycle_seq_chk #(
    .BANKS  (BANKS),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .nce       (nce),
    .cle       (cle),
    .ale       (ale),
    .nwe       (nwe),
    .nre       (nre),
    .dq_oe     (dq_oe),
    .rd_data   (rd_data)
);

// File: tb/nand_cycle_seq_test.sv
// Self-checking bench for the NAND sequencer: table-driven accesses,
// then directed checks for reset, mid-access changes and busy requests.
module nand_cycle_seq_test;

    typedef struct packed {
        logic [1:0] kind;
        logic       wr;
        logic [7:0] wdata;
        logic [1:0] bank;
        logic [7:0] setup;
        logic [7:0] wt;
        logic [7:0] hold;
        logic [7:0] hiz;
        logic [3:0] clr;
        logic [3:0] ar;
        logic [7:0] rdin;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1'b1, 8'h90, 2'd0, 8'd0,   8'd0, 8'd0,   8'd0,  4'd0,  4'd0,  8'h00},
        '{2'd2, 1'b0, 8'h00, 2'd1, 8'd1,   8'd2, 8'd0,   8'd5,  4'd3,  4'd7,  8'hA5},
        '{2'd1, 1'b1, 8'h3C, 2'd2, 8'd2,   8'd1, 8'd3,   8'd2,  4'd0,  4'd0,  8'h00},
        '{2'd2, 1'b0, 8'h00, 2'd3, 8'd0,   8'd3, 8'd1,   8'd0,  4'd9,  4'd5,  8'h5A},
        '{2'd2, 1'b0, 8'h00, 2'd0, 8'd1,   8'd0, 8'd0,   8'd0,  4'd15, 4'd15, 8'hC3},
        '{2'd3, 1'b1, 8'h7E, 2'd1, 8'd3,   8'd2, 8'd2,   8'd4,  4'd0,  4'd0,  8'h00},
        '{2'd0, 1'b0, 8'h11, 2'd2, 8'd0,   8'd0, 8'd0,   8'd10, 4'd0,  4'd0,  8'h00},
        '{2'd2, 1'b1, 8'hE7, 2'd3, 8'd255, 8'd4, 8'd255, 8'd0,  4'd15, 4'd0,  8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic       req_write = 1'b0;
    logic [7:0] req_wdata = 8'd0;
    logic [1:0] req_bank = 2'd0;
    logic [7:0] cfg_setup = 8'd0;
    logic [7:0] cfg_strobe = 8'd0;
    logic [7:0] cfg_hold = 8'd0;
    logic [7:0] cfg_hiz = 8'd0;
    logic [3:0] cfg_cle_re = 4'd0;
    logic [3:0] cfg_ale_re = 4'd0;
    logic [7:0] dq_in = 8'd0;
    logic       req_ready;
    logic       done;
    logic [7:0] rd_data;
    logic [3:0] nce;
    logic       cle;
    logic       ale;
    logic       nwe;
    logic       nre;
    logic [7:0] dq_out;
    logic       dq_oe;

    int tests = 0;
    int fails = 0;
    int prev_kind = 0;   // 0 none, 1 command, 2 address
    bit finished = 1'b0;

    always #2 clk = ~clk;

    nand_cycle_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .req_bank   (req_bank),
        .cfg_setup  (cfg_setup),
        .cfg_strobe (cfg_strobe),
        .cfg_hold   (cfg_hold),
        .cfg_hiz    (cfg_hiz),
        .cfg_cle_re (cfg_cle_re),
        .cfg_ale_re (cfg_ale_re),
        .dq_in      (dq_in),
        .req_ready  (req_ready),
        .done       (done),
        .rd_data    (rd_data),
        .nce        (nce),
        .cle        (cle),
        .ale        (ale),
        .nwe        (nwe),
        .nre        (nre),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

    task automatic check(input bit ok, input string req, input int cyc,
                         input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    // Run one access and compare every pin in every cycle against the
    // phase schedule derived from the requirements.
    task automatic run_access(input vec_t v, input bit mutate, input bit poke);
        int  t_len, s_len, w_len, h_len, total, last_strobe;
        bit  wr_eff, is_rd, turn, setup_p, strobe_p, hold_p, done_p, latch_p, act_p;
        bit  exp_oe;
        logic [8:0] act_v, exp_v;
        string tag;
        wr_eff = (v.kind < 2'd2) || v.wr;
        is_rd  = !wr_eff;
        t_len  = !is_rd ? 0 : (prev_kind == 1) ? int'(v.clr) + 1 :
                 (prev_kind == 2) ? int'(v.ar) + 1 : 0;
        s_len  = int'(v.setup) + 1;
        w_len  = int'(v.wt) + 1;
        h_len  = int'(v.hold) + 1;
        total  = t_len + s_len + w_len + h_len + 1;
        last_strobe = t_len + s_len + w_len;
        @(negedge clk);
        req_kind = v.kind; req_write = v.wr; req_wdata = v.wdata; req_bank = v.bank;
        cfg_setup = v.setup; cfg_strobe = v.wt; cfg_hold = v.hold; cfg_hiz = v.hiz;
        cfg_cle_re = v.clr; cfg_ale_re = v.ar;
        dq_in = ~v.rdin;
        req_valid = 1'b1;
        check(req_ready == 1'b1, "R5 ready in idle", 0, {15'd0, req_ready}, 16'd1);
        for (int c = 1; c <= total; c++) begin
            @(negedge clk);
            if (c == 1) begin
                req_valid = poke;
                if (poke) begin
                    req_kind = 2'd1; req_write = ~v.wr; req_bank = ~v.bank;
                end
                if (mutate) begin
                    req_kind = ~v.kind; req_write = ~v.wr; req_wdata = ~v.wdata;
                    req_bank = ~v.bank; cfg_setup = ~v.setup; cfg_strobe = ~v.wt;
                    cfg_hold = ~v.hold; cfg_hiz = ~v.hiz;
                    cfg_cle_re = ~v.clr; cfg_ale_re = ~v.ar;
                end
            end
            if (c == total) req_valid = 1'b0;
            turn     = (c <= t_len);
            setup_p  = !turn && (c <= t_len + s_len);
            strobe_p = !turn && !setup_p && (c <= last_strobe);
            hold_p   = !turn && !setup_p && !strobe_p && (c < total);
            done_p   = (c == total);
            latch_p  = setup_p || strobe_p || hold_p;
            act_p    = latch_p || turn;
            exp_v = {(act_p ? ~(4'b0001 << v.bank) : 4'hF),
                     latch_p && (v.kind == 2'd0),
                     latch_p && (v.kind == 2'd1),
                     !(strobe_p && wr_eff),
                     !(strobe_p && is_rd),
                     done_p};
            act_v = {nce, cle, ale, nwe, nre, done};
            tag = mutate ? "R10 latched fields" : poke ? "R5 busy request ignored" :
                  turn ? "R8 turnaround" : setup_p ? "R3 setup" :
                  strobe_p ? "R4 strobe" : hold_p ? "R5 hold" : "R5 done";
            check(act_v == exp_v, tag, c, {7'd0, act_v}, {7'd0, exp_v});
            exp_oe = latch_p && wr_eff && (c > int'(v.hiz));
            check(dq_oe == exp_oe, mutate ? "R10 release window" : "R6 bus enable",
                  c, {15'd0, dq_oe}, {15'd0, exp_oe});
            if (latch_p && wr_eff)
                check(dq_out == v.wdata, "R5 write byte held", c,
                      {8'd0, dq_out}, {8'd0, v.wdata});
            if (is_rd && c == last_strobe + 1)
                check(rd_data == v.rdin, "R7 capture on last strobe", c,
                      {8'd0, rd_data}, {8'd0, v.rdin});
            dq_in = (c == last_strobe) ? v.rdin : ~v.rdin;
        end
        @(negedge clk);
        check(req_ready && (nce == 4'hF) && !done, "R5 back to idle", total + 1,
              {11'd0, req_ready, nce}, {11'd0, 1'b1, 4'hF});
        if (is_rd)
            check(rd_data == v.rdin, "R7 read byte kept", total + 1,
                  {8'd0, rd_data}, {8'd0, v.rdin});
        if (poke) begin
            @(negedge clk);
            check(req_ready && (nce == 4'hF), "R5 busy request not replayed", total + 2,
                  {11'd0, req_ready, nce}, {11'd0, 1'b1, 4'hF});
        end
        prev_kind = (v.kind == 2'd0) ? 1 : (v.kind == 2'd1) ? 2 : 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        vec_t d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({nce, cle, ale, nwe, nre, dq_oe, done, req_ready} == {4'hF, 7'b0011001},
              "R1 reset pins", 0, {5'd0, nce, cle, ale, nwe, nre, dq_oe, done, req_ready},
              {5'd0, 4'hF, 7'b0011001});
        check(rd_data == 8'd0, "R1 reset read byte", 0, {8'd0, rd_data}, 16'd0);

        // Table of accesses: R2, R3, R4, R5, R6, R7, R8, R9
        for (int i = 0; i < NVEC; i++) begin
            run_access(VECS[i], 1'b0, 1'b0);
        end

        // R10: command write, all inputs changed after acceptance
        d = '{2'd0, 1'b1, 8'h70, 2'd1, 8'd2, 8'd1, 8'd1, 8'd1, 4'd0, 4'd0, 8'h00};
        run_access(d, 1'b1, 1'b0);
        // R10 with R8: read after command, delays changed mid-access
        d = '{2'd2, 1'b0, 8'h00, 2'd2, 8'd1, 8'd1, 8'd2, 8'd0, 4'd2, 4'd12, 8'h96};
        run_access(d, 1'b1, 1'b0);
        // R5: a request held during an access is ignored
        d = '{2'd2, 1'b1, 8'h4B, 2'd3, 8'd1, 8'd2, 8'd1, 8'd3, 4'd0, 4'd0, 8'h00};
        run_access(d, 1'b0, 1'b1);
        // R8: read after address with the largest address delay
        d = '{2'd1, 1'b1, 8'h02, 2'd0, 8'd0, 8'd0, 8'd0, 8'd0, 4'd0, 4'd0, 8'h00};
        run_access(d, 1'b0, 1'b0);
        d = '{2'd2, 1'b0, 8'h00, 2'd0, 8'd0, 8'd0, 8'd0, 8'd0, 4'd1, 4'd15, 8'h3E};
        run_access(d, 1'b0, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule